// File: doc/BRIEF.md
# Cascadable Bidirectional Column Data Sampler

This block is the digital input stage of an LCD column driver. On every rising clock edge it can take one 36-bit input word. The word holds six 6-bit gray codes, one per column ("dot"), and the block writes them into a column data register. By default there are 52 groups of six, so 312 columns. A start pulse arms a one-hot group pointer. The edge that samples the start pulse carries no valid data. Each of the following edges fills the next group. After the last group the pointer empties, so further clocks leave the register alone until a new start pulse arrives.

A direction input chooses the start pin and the fill order. With direction high, the right start input arms the pointer and groups fill upward from column 0. The left start pin then serves as the cascade output. With direction low everything is mirrored. The left start input arms the pointer, the columns fill downward from the top, and the right pin carries the cascade output. The cascade pulse is one clock wide and rises on the edge that stores the final group. That lets the next driver in a chain sample it as its own start on the following edge.

A per-edge inversion input stores every code bit-inverted. A rising edge on the line strobe empties the pointer, so capture stops until the next start pulse.

Top module: `cds_sampler`

## Requirements
- R1: While reset is asserted (rst_n low), every column code reads 0 and both cascade outputs are low.
- R2: Count the edge that samples an active start pulse as edge 0. With fill_asc high, edge j (1 ≤ j ≤ GROUPS) stores dot d of pix_i, bits [6d+5:6d] with bit 0 as LSB, into column 6(j-1)+d. Column c is held in col_q[6c+5:6c].
- R3: The word present on the edge that samples the start pulse is not stored.
- R4: With fill_asc low, edge j stores dot d into column 6·GROUPS-1-(6(j-1)+d), so the fill runs from the top column down.
- R5: With fill_asc high only rstart_i arms the pointer, and lstart_i has no effect. With fill_asc low only lstart_i arms it, and rstart_i has no effect.
- R6: Once edge GROUPS after the start has occurred, the cascade output is high for exactly one clock. The cascade output is lstart_o when fill_asc is high and rstart_o when fill_asc is low, and the other output stays low. lstart_oe equals fill_asc and rstart_oe equals its inverse.
- R7: Edges after edge GROUPS leave the column register unchanged until a new start pulse is sampled.
- R8: Edges before any start pulse has been sampled leave the column register unchanged.
- R9: When inv_i is high on a storing edge, each stored code is the bitwise inverse of the input code. When inv_i is low, the code is stored unchanged.
- R10: A rising edge on strobe_i, sampled by the clock, empties the pointer. That edge and later edges store nothing and give no cascade pulse until a new start pulse.
- R11: A start pulse sampled during a fill restarts the fill at group 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| fill_asc | input | 1 | 1: right pin is the start input and columns fill upward; 0: mirrored |
| rstart_i | input | 1 | Right start pin, input side |
| lstart_i | input | 1 | Left start pin, input side |
| pix_i | input | DOTS*CODE_W | Six gray codes per word, dot d in bits [6d+5:6d] |
| inv_i | input | 1 | Store codes bit-inverted when high |
| strobe_i | input | 1 | Line strobe; its rising edge empties the pointer |
| rstart_o | output | 1 | Right start pin, cascade output side |
| lstart_o | output | 1 | Left start pin, cascade output side |
| rstart_oe | output | 1 | Right pin drive enable (high when it is the cascade output) |
| lstart_oe | output | 1 | Left pin drive enable (high when it is the cascade output) |
| col_q | output | GROUPS*DOTS*CODE_W | Column data register, column c in bits [6c+5:6c] |

## Verification
A pointer holding a wrong value shows at the ports on the very next edge. A group is written to the wrong columns, a second group changes, or an idle edge changes the register. The per-clock comparison of col_q catches any of these one clock after the edge. A pointer that fails to empty or to shift shows up GROUPS edges later, when the cascade pulse comes late, early, twice or not at all. A strobe edge detector that misses its edge shows up on the next clock, because data keeps landing after the strobe.

// File: rtl/cds_pkg.sv
package cds_pkg;

  typedef enum logic {
    FILL_DESC = 1'b0,
    FILL_ASC  = 1'b1
  } fill_dir_e;

  // index of an element seen from the other end of a row of n
  function automatic int unsigned mirror_idx(input int unsigned i, input int unsigned n);
    return n - 1 - i;
  endfunction

  // flat column number of a dot inside a group
  function automatic int unsigned slot_of(input int unsigned grp, input int unsigned dot,
                                          input int unsigned dots);
    return grp * dots + dot;
  endfunction

  // lowest bit of a code inside a packed vector of codes
  function automatic int unsigned code_lsb(input int unsigned idx, input int unsigned code_w);
    return idx * code_w;
  endfunction

endpackage

// File: rtl/cds_pointer.sv
module cds_pointer #(
  parameter int unsigned GROUPS = 52
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_sel,
  input  logic              strobe_i,
  output logic [GROUPS-1:0] ptr_q,
  output logic [GROUPS-1:0] wr_oh,
  output logic              casc_q,
  output logic              strobe_rise
);

  localparam int unsigned LAST = GROUPS - 1;

  logic              strobe_q;
  logic [GROUPS-1:0] ptr_d;
  logic              casc_d;

  assign strobe_rise = strobe_i & ~strobe_q;

  // the group selected during this cycle is written on the closing edge
  assign wr_oh = strobe_rise ? '0 : ptr_q;

  always_comb begin
    if (strobe_rise) begin
      ptr_d  = '0;
      casc_d = 1'b0;
    end else begin
      casc_d = ptr_q[LAST];
      if (start_sel) ptr_d = GROUPS'(1);
      else           ptr_d = ptr_q << 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      ptr_q    <= '0;
      casc_q   <= 1'b0;
    end else begin
      strobe_q <= strobe_i;
      ptr_q    <= ptr_d;
      casc_q   <= casc_d;
    end
  end

endmodule

// File: rtl/cds_code_xform.sv
module cds_code_xform #(
  parameter int unsigned DOTS   = 6,
  parameter int unsigned CODE_W = 6,
  localparam int unsigned WORD_W = DOTS * CODE_W
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic              inv_i,
  output logic [WORD_W-1:0] word_o
);
  import cds_pkg::*;

  for (genvar d = 0; d < DOTS; d++) begin : g_dot
    localparam int unsigned LSB = code_lsb(d, CODE_W);
    assign word_o[LSB +: CODE_W] = inv_i ? ~word_i[LSB +: CODE_W] : word_i[LSB +: CODE_W];
  end

endmodule

// File: rtl/cds_column_reg.sv
module cds_column_reg #(
  parameter int unsigned GROUPS = 52,
  parameter int unsigned DOTS   = 6,
  parameter int unsigned CODE_W = 6,
  localparam int unsigned WORD_W = DOTS * CODE_W,
  localparam int unsigned COLS   = GROUPS * DOTS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   asc,
  input  logic [GROUPS-1:0]      wr_oh,
  input  logic [WORD_W-1:0]      word,
  output logic [COLS*CODE_W-1:0] col_q
);
  import cds_pkg::*;

  for (genvar pg = 0; pg < GROUPS; pg++) begin : g_grp
    localparam int unsigned SRC_G_DESC = mirror_idx(pg, GROUPS);
    logic wen;
    // physical group pg is logical group pg ascending, mirrored descending
    assign wen = asc ? wr_oh[pg] : wr_oh[SRC_G_DESC];

    for (genvar ps = 0; ps < DOTS; ps++) begin : g_dot
      localparam int unsigned SRC_D_DESC = mirror_idx(ps, DOTS);
      localparam int unsigned ASC_LSB    = code_lsb(ps, CODE_W);
      localparam int unsigned DESC_LSB   = code_lsb(SRC_D_DESC, CODE_W);
      localparam int unsigned COL_LSB    = code_lsb(slot_of(pg, ps, DOTS), CODE_W);

      logic [CODE_W-1:0] cell_q;
      logic [CODE_W-1:0] cell_d;

      assign cell_d = asc ? word[ASC_LSB +: CODE_W] : word[DESC_LSB +: CODE_W];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cell_q <= '0;
        else if (wen) cell_q <= cell_d;
      end

      assign col_q[COL_LSB +: CODE_W] = cell_q;
    end
  end

endmodule

// File: rtl/cds_sampler.sv
module cds_sampler #(
  parameter int unsigned GROUPS = 52,
  parameter int unsigned DOTS   = 6,
  parameter int unsigned CODE_W = 6,
  localparam int unsigned WORD_W = DOTS * CODE_W,
  localparam int unsigned COLS   = GROUPS * DOTS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fill_asc,
  input  logic                   rstart_i,
  input  logic                   lstart_i,
  input  logic [WORD_W-1:0]      pix_i,
  input  logic                   inv_i,
  input  logic                   strobe_i,
  output logic                   rstart_o,
  output logic                   lstart_o,
  output logic                   rstart_oe,
  output logic                   lstart_oe,
  output logic [COLS*CODE_W-1:0] col_q
);
  import cds_pkg::*;

  fill_dir_e         dir;
  logic              start_sel;
  logic [GROUPS-1:0] ptr_q;
  logic [GROUPS-1:0] wr_oh;
  logic              casc_q;
  logic              strobe_rise;
  logic [WORD_W-1:0] word_x;

  assign dir       = fill_dir_e'(fill_asc);
  assign start_sel = (dir == FILL_ASC) ? rstart_i : lstart_i;

  cds_pointer #(.GROUPS(GROUPS)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_sel  (start_sel),
    .strobe_i   (strobe_i),
    .ptr_q      (ptr_q),
    .wr_oh      (wr_oh),
    .casc_q     (casc_q),
    .strobe_rise(strobe_rise)
  );

  cds_code_xform #(.DOTS(DOTS), .CODE_W(CODE_W)) u_xf (
    .word_i(pix_i),
    .inv_i (inv_i),
    .word_o(word_x)
  );

  cds_column_reg #(.GROUPS(GROUPS), .DOTS(DOTS), .CODE_W(CODE_W)) u_cols (
    .clk  (clk),
    .rst_n(rst_n),
    .asc  (dir == FILL_ASC),
    .wr_oh(wr_oh),
    .word (word_x),
    .col_q(col_q)
  );

  // the pin opposite the start input carries the cascade pulse
  assign lstart_o  = (dir == FILL_ASC) & casc_q;
  assign rstart_o  = (dir == FILL_DESC) & casc_q;
  assign lstart_oe = (dir == FILL_ASC);
  assign rstart_oe = (dir == FILL_DESC);

endmodule

// File: rtl/cds_sampler_chk.sv
module cds_sampler_chk #(
  parameter int unsigned GROUPS = 52,
  parameter int unsigned DOTS   = 6,
  parameter int unsigned CODE_W = 6,
  localparam int unsigned COLS  = GROUPS * DOTS
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   lstart_o,
  input logic                   rstart_o,
  input logic                   start_sel,
  input logic                   strobe_rise,
  input logic [GROUPS-1:0]      ptr_q,
  input logic [GROUPS-1:0]      wr_oh,
  input logic [COLS*CODE_W-1:0] col_q
);

  a_r2_ptr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ptr_q));

  a_r6_casc_side: assert property (@(posedge clk) disable iff (!rst_n)
    !(lstart_o && rstart_o));

  a_r6_casc_single: assert property (@(posedge clk) disable iff (!rst_n)
    (lstart_o || rstart_o) |=> !(lstart_o || rstart_o));

  a_r6_casc_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_q[GROUPS-1] && !strobe_rise) |=> (lstart_o || rstart_o));

  a_r10_strobe_clear: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_rise |=> (ptr_q == '0));

  a_r11_start_arms: assert property (@(posedge clk) disable iff (!rst_n)
    (start_sel && !strobe_rise) |=> (ptr_q == GROUPS'(1)));

  a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_oh == '0) |=> $stable(col_q));

endmodule

bind cds_sampler cds_sampler_chk #(.GROUPS(GROUPS), .DOTS(DOTS), .CODE_W(CODE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lstart_o   (lstart_o),
  .rstart_o   (rstart_o),
  .start_sel  (start_sel),
  .strobe_rise(strobe_rise),
  .ptr_q      (ptr_q),
  .wr_oh      (wr_oh),
  .col_q      (col_q)
);

// File: tb/sim_cds_sampler.sv
module sim_cds_sampler;
  localparam int G    = 4;
  localparam int DOTS = 6;
  localparam int CW   = 6;
  localparam int COLS = G * DOTS;
  localparam int WW   = DOTS * CW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fill_asc = 1'b1, rstart_i = 1'b0, lstart_i = 1'b0, inv_i = 1'b0, strobe_i = 1'b0;
  logic [WW-1:0] pix_i = '0;
  logic rstart_o, lstart_o, rstart_oe, lstart_oe;
  logic [COLS*CW-1:0] col_q;

  always #4 clk = ~clk;

  cds_sampler #(.GROUPS(G), .DOTS(DOTS), .CODE_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .fill_asc(fill_asc), .rstart_i(rstart_i), .lstart_i(lstart_i),
    .pix_i(pix_i), .inv_i(inv_i), .strobe_i(strobe_i), .rstart_o(rstart_o), .lstart_o(lstart_o),
    .rstart_oe(rstart_oe), .lstart_oe(lstart_oe), .col_q(col_q)
  );

  int checks = 0;
  int errors = 0;
  int casc_seen = 0;
  string cur_req = "R8";

  // behavioural reference: k = edges since the start pulse, -1 when idle
  int k = -1;
  logic sprev = 1'b0;
  logic exp_casc = 1'b0;
  logic [COLS*CW-1:0] exp_cols = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      k = -1; sprev = 1'b0; exp_casc = 1'b0; exp_cols = '0;
    end else begin
      logic rise, st;
      int j;
      rise  = strobe_i && !sprev;
      sprev = strobe_i;
      st    = fill_asc ? rstart_i : lstart_i;
      if (rise) begin
        k = -1; exp_casc = 1'b0;
      end else begin
        j = (k >= 0) ? k + 1 : -1;
        if (j >= 1 && j <= G) begin
          for (int d = 0; d < DOTS; d++) begin
            int pos, c;
            pos = (j - 1) * DOTS + d;
            c   = fill_asc ? pos : COLS - 1 - pos;
            exp_cols[c*CW +: CW] = pix_i[d*CW +: CW] ^ {CW{inv_i}};
          end
        end
        exp_casc = (j == G);
        if (st) k = 0;
        else if (j >= 1 && j < G + 2) k = j;
        else k = -1;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      checks++;
      if (col_q !== '0 || lstart_o !== 1'b0 || rstart_o !== 1'b0) begin
        errors++;
        $display("FAIL R1 reset state: cols=%h l=%b r=%b expected cols=0 l=0 r=0", col_q, lstart_o, rstart_o);
      end
    end else begin
      checks++;
      if (col_q !== exp_cols) begin
        errors++;
        $display("FAIL %s columns: actual=%h expected=%h", cur_req, col_q, exp_cols);
      end
      checks++;
      if (lstart_o !== (fill_asc & exp_casc) || rstart_o !== (~fill_asc & exp_casc)) begin
        errors++;
        $display("FAIL R6 cascade: actual l=%b r=%b expected l=%b r=%b", lstart_o, rstart_o,
                 fill_asc & exp_casc, ~fill_asc & exp_casc);
      end
      checks++;
      if (lstart_oe !== fill_asc || rstart_oe !== ~fill_asc) begin
        errors++;
        $display("FAIL R6 drive enables: actual l=%b r=%b expected l=%b r=%b", lstart_oe, rstart_oe,
                 fill_asc, ~fill_asc);
      end
      if (lstart_o || rstart_o) casc_seen++;
    end
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      pix_i = {$urandom, $urandom};
      rstart_i = 1'b0; lstart_i = 1'b0;
    end
  endtask

  task automatic pulse_start(logic right);
    @(negedge clk); #1;
    pix_i = {$urandom, $urandom};
    if (right) rstart_i = 1'b1; else lstart_i = 1'b1;
  endtask

  task automatic expect_casc(int n, string req);
    checks++;
    if (casc_seen != n) begin
      errors++;
      $display("FAIL %s cascade count: actual=%0d expected=%0d", req, casc_seen, n);
    end
    casc_seen = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    cur_req = "R8 idle before start";      tick(5);
    cur_req = "R2 R3 forward fill";        pulse_start(1'b1); tick(G);
    cur_req = "R7 halt after last group";  tick(6);
    expect_casc(1, "R6");
    cur_req = "R5 left pin ignored";       pulse_start(1'b0); tick(G + 3);
    expect_casc(0, "R5");
    cur_req = "R9 inversion";
    pulse_start(1'b1);
    for (int i = 0; i < G + 2; i++) begin
      @(negedge clk); #1;
      rstart_i = 1'b0; inv_i = i[0]; pix_i = {$urandom, $urandom};
    end
    inv_i = 1'b0; tick(2);
    expect_casc(1, "R9");
    fill_asc = 1'b0;
    cur_req = "R4 reverse fill";           tick(2); pulse_start(1'b0); tick(G + 3);
    expect_casc(1, "R4");
    cur_req = "R5 right pin ignored";      pulse_start(1'b1); tick(G + 3);
    expect_casc(0, "R5");
    fill_asc = 1'b1;
    cur_req = "R10 strobe clear";          pulse_start(1'b1); tick(2);
    strobe_i = 1'b1; tick(1); strobe_i = 1'b0; tick(G + 3);
    expect_casc(0, "R10");
    cur_req = "R11 restart";               pulse_start(1'b1); tick(2);
    pulse_start(1'b1); tick(G + 3);
    expect_casc(1, "R11");
    cur_req = "R4 R11 reverse restart";    fill_asc = 1'b0; tick(1);
    pulse_start(1'b0); tick(1); pulse_start(1'b0); tick(G + 3);
    expect_casc(1, "R4");
    tick(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule